// File: doc/BRIEF.md
# Switching Protection Supervisor with Timed Auto-Restart

This block sits between the digitised comparators of an offline switching converter and its gate driver. It watches the current-sense thresholds, the feedback level, the supply comparators, the line zero-cross strobes and a junction temperature code. When any of six fault conditions appears while the converter is switching, it stops switching and records which fault came first. It then runs a fixed restart wait.

During the restart wait, the block keeps the controller supply inside a window by switching the high-voltage bias source with hysteresis. When the wait ends, it turns the bias off and lets the supply sag to its turn-off level. At that point it issues a one-cycle restart request and goes back to the start-up state. Switching resumes once the supply has recharged to its turn-on level and the thermal flag has cleared.

All timing runs on external millisecond and microsecond tick strobes. This means a test can scale the limits down through parameters.

Top module: `prot_supervisor`

## Requirements
- R1: After reset, and in the start-up state, `gate_inhibit_o`=1, `bias_en_o`=1, `restart_o`=0 and `fault_cause_o`=0. The block leaves start-up on the first clock edge at which `vdd_on_i`=1 and the thermal flag is clear. From the next cycle on, `gate_inhibit_o`=0 and `bias_en_o`=0.
- R2: While switching, `cs_ocp_i`=1 in a cycle with `gate_on_i`=1 is an over-current fault, cause code 1. `cs_ocp_i` outside the on-time is ignored.
- R3: An over-load fault (code 6) is raised at the `zc_i` strobe that closes the OLP_ZC-th consecutive line interval containing at least one `cs_lim_i` cycle. A `cs_lim_i` cycle that coincides with the closing strobe counts for that interval. An interval with no `cs_lim_i` cycle resets the count.
- R4: An output-short fault (code 5) is raised on the OSP_MS-th `ms_tick_i` seen while `fb_short_i` has stayed high. Any cycle with `fb_short_i`=0 restarts the count.
- R5: During the first on-time after entering the switching state, if `cs_min_i` is never high while `gate_on_i`=1, a sense-resistor short fault (code 4) is raised in the cycle `gate_on_i` falls. Later pulses are not checked.
- R6: A supply over-voltage fault (code 2) is raised on the VOVP_US-th `us_tick_i` seen while `vdd_ovp_i` has stayed high. A low cycle restarts the count.
- R7: The thermal flag sets when `temp_i` > TSD_HI and clears when `temp_i` < TSD_LO, with a one-cycle register delay. While the flag is set in the switching state, it is a thermal fault (code 3). While it is set in start-up, it blocks the return to switching.
- R8: Any fault moves the block out of switching at the next edge, so `gate_inhibit_o`=1 from that cycle. `fault_cause_o` records only the first fault since `rst_ni`. The priority within one cycle is 1 > 2 > 3 > 4 > 5 > 6. Faults outside the switching state are ignored, and restart does not clear the code.
- R9: In the restart wait, `gate_inhibit_o` stays 1 until the AR_MS-th `ms_tick_i` in that state. `bias_en_o` starts at 0 on entry. One cycle after `vdd_mid_i`=0 it becomes 1. One cycle after `vdd_hi_i`=1 (with `vdd_mid_i`=1) it becomes 0. Otherwise it holds.
- R10: After the wait, `bias_en_o`=0 until `vdd_uv_i`=1. The cycle after that, `restart_o` is high for exactly one cycle and the block is back in start-up (R1 outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| gate_on_i | input | 1 | Gate on-time window |
| cs_min_i | input | 1 | Current sense above 75 mV |
| cs_lim_i | input | 1 | Current sense above 1.2 V limit |
| cs_ocp_i | input | 1 | Current sense above 1.8 V |
| fb_short_i | input | 1 | Feedback sample below 0.7 V |
| vdd_ovp_i | input | 1 | Supply above 25 V |
| vdd_hi_i | input | 1 | Supply above 19 V |
| vdd_mid_i | input | 1 | Supply above 17 V |
| vdd_on_i | input | 1 | Supply at or above 16 V |
| vdd_uv_i | input | 1 | Supply at or below 7.75 V |
| zc_i | input | 1 | Line zero-cross strobe |
| temp_i | input | TEMP_W | Junction temperature code, degrees |
| gate_inhibit_o | output | 1 | Switching blocked |
| bias_en_o | output | 1 | High-voltage bias source on |
| fault_cause_o | output | 3 | First fault code, 0 = none |
| restart_o | output | 1 | One-cycle restart request |

## Verification
Every fault detector is combinational on its registered counters and the current inputs. As a result, a fault is visible at the outputs exactly one edge after the cycle that completes it. The exception is the thermal fault, which needs two edges: one for the hysteresis flag and one for the state. Bias regulation lags its comparators by one edge, and `restart_o` appears one edge after `vdd_uv_i`. The bench drives inputs just after a rising edge and samples just after the following edge. Each count is swept tick by tick, including the last tick before the limit and an interrupted run, so an off-by-one in any limit shows at a named step.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } sup_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_OCP    = 3'd1,
    CAUSE_VOVP   = 3'd2,
    CAUSE_TSD    = 3'd3,
    CAUSE_RSHORT = 3'd4,
    CAUSE_OSHORT = 3'd5,
    CAUSE_OLOAD  = 3'd6
  } cause_e;

  // fault vector index i carries cause code i+1; lower index wins
  localparam int unsigned NUM_FAULTS = 6;
endpackage

// File: rtl/prot_persist_timer.sv
module prot_persist_timer #(
  parameter int unsigned LIMIT = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cond_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i & cond_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!en_i || !cond_i)      cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/prot_olp_counter.sv
module prot_olp_counter #(
  parameter int unsigned LIMIT = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lim_i,
  input  logic zc_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          ev;

  assign ev    = seen_q | lim_i;
  assign hit_o = en_i & zc_i & ev & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (zc_i) begin
      seen_q <= 1'b0;
      if (!ev)                cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end else if (lim_i) begin
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/prot_thermal.sv
module prot_thermal #(
  parameter int unsigned TW = 8,
  parameter int unsigned HI = 150,
  parameter int unsigned LO = 120
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] temp_i,
  output logic          tsd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tsd_o <= 1'b0;
    else if (temp_i > TW'(HI))   tsd_o <= 1'b1;
    else if (temp_i < TW'(LO))   tsd_o <= 1'b0;
  end
endmodule

// File: rtl/prot_restart_fsm.sv
module prot_restart_fsm
  import prot_pkg::*;
#(
  parameter int unsigned AR_MS = 3000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fault_i,
  input  logic       ms_tick_i,
  input  logic       vdd_on_i,
  input  logic       vdd_mid_i,
  input  logic       vdd_hi_i,
  input  logic       vdd_uv_i,
  input  logic       tsd_i,
  output sup_state_e state_o,
  output logic       bias_en_o,
  output logic       restart_o
);
  sup_state_e state_q, state_d;
  logic       reg_bias_q;
  logic       hold_done;

  prot_persist_timer #(.LIMIT(AR_MS)) u_hold (
    .clk_i, .rst_ni,
    .en_i  (state_q == ST_HOLD),
    .cond_i(1'b1),
    .tick_i(ms_tick_i),
    .hit_o (hold_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START: if (vdd_on_i && !tsd_i) state_d = ST_RUN;
      ST_RUN:   if (fault_i)            state_d = ST_HOLD;
      ST_HOLD:  if (hold_done)          state_d = ST_DRAIN;
      ST_DRAIN: if (vdd_uv_i)           state_d = ST_START;
      default:                          state_d = ST_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_START;
      reg_bias_q <= 1'b0;
      restart_o  <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_o <= (state_q == ST_DRAIN) && vdd_uv_i;
      // hysteretic bias: on below 17 V, off above 19 V
      if (state_q != ST_HOLD) reg_bias_q <= 1'b0;
      else if (!vdd_mid_i)    reg_bias_q <= 1'b1;
      else if (vdd_hi_i)      reg_bias_q <= 1'b0;
    end
  end

  assign state_o   = state_q;
  assign bias_en_o = (state_q == ST_START) | ((state_q == ST_HOLD) & reg_bias_q);
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_pkg::*;
#(
  parameter int unsigned OLP_ZC   = 60,
  parameter int unsigned OSP_MS   = 35,
  parameter int unsigned VOVP_US  = 10,
  parameter int unsigned AR_MS    = 3000,
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned TSD_HI   = 150,
  parameter int unsigned TSD_LO   = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              us_tick_i,
  input  logic              gate_on_i,
  input  logic              cs_min_i,
  input  logic              cs_lim_i,
  input  logic              cs_ocp_i,
  input  logic              fb_short_i,
  input  logic              vdd_ovp_i,
  input  logic              vdd_hi_i,
  input  logic              vdd_mid_i,
  input  logic              vdd_on_i,
  input  logic              vdd_uv_i,
  input  logic              zc_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              gate_inhibit_o,
  output logic              bias_en_o,
  output logic [2:0]        fault_cause_o,
  output logic              restart_o
);
  sup_state_e             sup_state;
  logic                   run;
  logic                   tsd;
  logic                   vovp_hit, osp_hit, olp_hit;
  logic                   gate_q, first_q, seen_q;
  logic [NUM_FAULTS-1:0]  fault_vec;
  logic                   fault_any;
  cause_e                 cause_sel, cause_q;

  assign run = (sup_state == ST_RUN);

  prot_thermal #(.TW(TEMP_W), .HI(TSD_HI), .LO(TSD_LO)) u_thermal (
    .clk_i, .rst_ni, .temp_i, .tsd_o(tsd)
  );

  prot_persist_timer #(.LIMIT(VOVP_US)) u_vovp (
    .clk_i, .rst_ni, .en_i(run), .cond_i(vdd_ovp_i), .tick_i(us_tick_i), .hit_o(vovp_hit)
  );

  prot_persist_timer #(.LIMIT(OSP_MS)) u_osp (
    .clk_i, .rst_ni, .en_i(run), .cond_i(fb_short_i), .tick_i(ms_tick_i), .hit_o(osp_hit)
  );

  prot_olp_counter #(.LIMIT(OLP_ZC)) u_olp (
    .clk_i, .rst_ni, .en_i(run), .lim_i(cs_lim_i), .zc_i, .hit_o(olp_hit)
  );

  // first-pulse sense resistor check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      first_q <= 1'b1;
      seen_q  <= 1'b0;
    end else if (!run) begin
      gate_q  <= 1'b0;
      first_q <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      gate_q <= gate_on_i;
      if (gate_on_i && cs_min_i)  seen_q  <= 1'b1;
      if (gate_q && !gate_on_i)   first_q <= 1'b0;
    end
  end

  assign fault_vec[0] = run & gate_on_i & cs_ocp_i;
  assign fault_vec[1] = vovp_hit;
  assign fault_vec[2] = run & tsd;
  assign fault_vec[3] = run & first_q & gate_q & ~gate_on_i & ~seen_q;
  assign fault_vec[4] = osp_hit;
  assign fault_vec[5] = olp_hit;
  assign fault_any    = |fault_vec;

  always_comb begin
    cause_sel = CAUSE_NONE;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (fault_vec[i]) cause_sel = cause_e'(3'(i + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cause_q <= CAUSE_NONE;
    else if (cause_q == CAUSE_NONE && fault_any)   cause_q <= cause_sel;
  end

  prot_restart_fsm #(.AR_MS(AR_MS)) u_fsm (
    .clk_i, .rst_ni,
    .fault_i  (fault_any),
    .ms_tick_i,
    .vdd_on_i, .vdd_mid_i, .vdd_hi_i, .vdd_uv_i,
    .tsd_i    (tsd),
    .state_o  (sup_state),
    .bias_en_o,
    .restart_o
  );

  assign gate_inhibit_o = ~run;
  assign fault_cause_o  = cause_q;
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] state_i,
  input logic       vdd_hi_i,
  input logic       vdd_mid_i,
  input logic       bias_en_o,
  input logic       gate_inhibit_o,
  input logic [2:0] fault_cause_o,
  input logic       restart_o
);
  localparam logic [1:0] S_HOLD  = 2'd2;
  localparam logic [1:0] S_DRAIN = 2'd3;

  assert_restart_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

  assert_restart_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (gate_inhibit_o && bias_en_o));

  assert_drain_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DRAIN) |-> (!bias_en_o && gate_inhibit_o));

  assert_cause_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_cause_o != 3'd0) |=> $stable(fault_cause_o));

  assert_cause_inhibit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fault_cause_o != 3'd0) && ($past(fault_cause_o) == 3'd0)) |-> gate_inhibit_o);

  assert_bias_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == S_HOLD) && ($past(state_i) == S_HOLD) && $past(!vdd_mid_i)) |-> bias_en_o);

  assert_bias_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == S_HOLD) && ($past(state_i) == S_HOLD) && $past(vdd_mid_i && vdd_hi_i))
      |-> !bias_en_o);
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (
  .clk_i,
  .rst_ni,
  .state_i       (sup_state),
  .vdd_hi_i,
  .vdd_mid_i,
  .bias_en_o,
  .gate_inhibit_o,
  .fault_cause_o,
  .restart_o
);

// File: tb/prot_supervisor_test.sv
module prot_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int OLP_N = 4;
  localparam int OSP_N = 5;
  localparam int OVP_N = 3;
  localparam int AR_N  = 6;
  localparam int T_HI  = 150;
  localparam int T_LO  = 120;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ms_tick = 0, us_tick = 0, gate_on = 0, cs_min = 0, cs_lim = 0, cs_ocp = 0;
  logic fb_short = 0, vdd_ovp = 0, vdd_hi = 0, vdd_mid = 1, vdd_on = 1, vdd_uv = 0, zc = 0;
  logic [7:0] temp = 8'd25;
  logic inhibit, bias, restart;
  logic [2:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_supervisor #(
    .OLP_ZC(OLP_N), .OSP_MS(OSP_N), .VOVP_US(OVP_N), .AR_MS(AR_N),
    .TEMP_W(8), .TSD_HI(T_HI), .TSD_LO(T_LO)
  ) uut (
    .clk_i(clk), .rst_ni, .ms_tick_i(ms_tick), .us_tick_i(us_tick),
    .gate_on_i(gate_on), .cs_min_i(cs_min), .cs_lim_i(cs_lim), .cs_ocp_i(cs_ocp),
    .fb_short_i(fb_short), .vdd_ovp_i(vdd_ovp), .vdd_hi_i(vdd_hi), .vdd_mid_i(vdd_mid),
    .vdd_on_i(vdd_on), .vdd_uv_i(vdd_uv), .zc_i(zc), .temp_i(temp),
    .gate_inhibit_o(inhibit), .bias_en_o(bias), .fault_cause_o(cause), .restart_o(restart)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ms_pulse();
    ms_tick = 1; step(); ms_tick = 0; step();
  endtask

  task automatic us_pulse();
    us_tick = 1; step(); us_tick = 0; step();
  endtask

  task automatic interval_ev();
    cs_lim = 1; step(); cs_lim = 0; step(); zc = 1; step(); zc = 0; step();
  endtask

  task automatic interval_empty();
    step(); zc = 1; step(); zc = 0; step();
  endtask

  task automatic boot();
    ms_tick = 0; us_tick = 0; gate_on = 0; cs_min = 0; cs_lim = 0; cs_ocp = 0;
    fb_short = 0; vdd_ovp = 0; vdd_hi = 0; vdd_mid = 1; vdd_on = 1; vdd_uv = 0; zc = 0;
    temp = 8'd25;
    rst_ni = 0; step(); step(); rst_ni = 1;
    step();
    gate_on = 1; cs_min = 1; step();
    gate_on = 0; cs_min = 0; step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset and start-up
    vdd_on = 0;
    rst_ni = 0; step(); step();
    check("R1 reset inhibit", inhibit, 1);
    check("R1 reset bias", bias, 1);
    check("R1 reset cause", cause, 0);
    check("R1 reset restart", restart, 0);
    rst_ni = 1; step(); step();
    check("R1 wait vdd_on inhibit", inhibit, 1);
    vdd_on = 1; step();
    check("R1 running inhibit", inhibit, 0);
    check("R1 running bias", bias, 0);

    // R5 first pulse without 75 mV crossing
    boot();
    check("R5 good first pulse", inhibit, 0);
    gate_on = 1; step(); gate_on = 0; step();
    check("R5 second pulse unchecked", inhibit, 0);
    rst_ni = 0; step(); rst_ni = 1; step();
    gate_on = 1; step(); step();
    check("R5 during pulse", inhibit, 0);
    gate_on = 0; step();
    check("R5 sense short inhibit", inhibit, 1);
    check("R5 sense short cause", cause, 4);

    // R2 over-current
    boot();
    cs_ocp = 1; step();
    check("R2 ocp outside on-time", inhibit, 0);
    gate_on = 1; step();
    check("R2 ocp inhibit", inhibit, 1);
    check("R2 ocp cause", cause, 1);
    gate_on = 0; cs_ocp = 0;

    // R3 over-load sweep over event-interval counts
    for (int k = 1; k <= OLP_N; k++) begin
      boot();
      for (int j = 0; j < k; j++) interval_ev();
      check($sformatf("R3 olp after %0d intervals", k), inhibit, (k == OLP_N) ? 1 : 0);
      if (k == OLP_N) check("R3 olp cause", cause, 6);
    end
    boot();
    for (int j = 0; j < OLP_N - 1; j++) interval_ev();
    interval_empty();
    for (int j = 0; j < OLP_N - 1; j++) interval_ev();
    check("R3 olp count cleared by empty interval", inhibit, 0);
    cs_lim = 1; zc = 1; step(); cs_lim = 0; zc = 0; step();
    check("R3 olp event on closing strobe", cause, 6);

    // R4 output short sweep
    boot();
    fb_short = 1;
    for (int i = 1; i <= OSP_N; i++) begin
      ms_pulse();
      check($sformatf("R4 osp tick %0d", i), inhibit, (i == OSP_N) ? 1 : 0);
    end
    check("R4 osp cause", cause, 5);
    boot();
    fb_short = 1;
    for (int i = 0; i < OSP_N - 1; i++) ms_pulse();
    fb_short = 0; step(); fb_short = 1;
    for (int i = 0; i < OSP_N - 1; i++) ms_pulse();
    check("R4 osp interrupted", inhibit, 0);
    ms_pulse();
    check("R4 osp after restart of count", cause, 5);

    // R6 supply over-voltage sweep
    boot();
    vdd_ovp = 1;
    for (int i = 1; i <= OVP_N; i++) begin
      us_pulse();
      check($sformatf("R6 vovp tick %0d", i), inhibit, (i == OVP_N) ? 1 : 0);
    end
    check("R6 vovp cause", cause, 2);
    boot();
    vdd_ovp = 1;
    for (int i = 0; i < OVP_N - 1; i++) us_pulse();
    vdd_ovp = 0; step(); vdd_ovp = 1;
    for (int i = 0; i < OVP_N - 1; i++) us_pulse();
    check("R6 vovp interrupted", inhibit, 0);

    // R8 priority: over-current beats supply over-voltage in one cycle
    boot();
    vdd_ovp = 1;
    for (int i = 0; i < OVP_N - 1; i++) us_pulse();
    us_tick = 1; gate_on = 1; cs_ocp = 1; step();
    us_tick = 0; gate_on = 0; cs_ocp = 0; step();
    check("R8 priority ocp over vovp", cause, 1);
    // R8 priority: output short beats over-load
    boot();
    fb_short = 1;
    for (int i = 0; i < OSP_N - 1; i++) ms_pulse();
    for (int j = 0; j < OLP_N - 1; j++) interval_ev();
    check("R8 no fault before coincident hits", inhibit, 0);
    ms_tick = 1; cs_lim = 1; zc = 1; step();
    ms_tick = 0; cs_lim = 0; zc = 0; step();
    check("R8 priority osp over olp", cause, 5);

    // R7 thermal threshold, then R9/R10 restart loop
    boot();
    temp = 8'(T_HI); step(); step();
    check("R7 at threshold no fault", inhibit, 0);
    temp = 8'(T_HI + 1); step();
    check("R7 flag delay", inhibit, 0);
    step();
    check("R7 thermal inhibit", inhibit, 1);
    check("R7 thermal cause", cause, 3);
    check("R9 hold entry bias", bias, 0);
    vdd_mid = 0; step();
    check("R9 bias on below window", bias, 1);
    vdd_mid = 1; step();
    check("R9 bias holds inside window", bias, 1);
    vdd_hi = 1; step();
    check("R9 bias off above window", bias, 0);
    vdd_hi = 0; step();
    check("R9 bias stays off inside window", bias, 0);
    gate_on = 1; cs_ocp = 1; step(); gate_on = 0; cs_ocp = 0; step();
    check("R8 fault ignored in hold", cause, 3);
    vdd_mid = 0; step();
    for (int i = 0; i < AR_N - 1; i++) ms_pulse();
    check("R9 hold before last tick inhibit", inhibit, 1);
    check("R9 hold before last tick bias", bias, 1);
    ms_tick = 1; step(); ms_tick = 0;
    check("R10 drain bias off", bias, 0);
    check("R10 drain inhibit", inhibit, 1);
    step(); step();
    check("R10 drain waits for uv", restart, 0);
    vdd_uv = 1; step(); vdd_uv = 0;
    check("R10 restart pulse", restart, 1);
    check("R10 back in start-up bias", bias, 1);
    step();
    check("R10 restart one cycle", restart, 0);
    vdd_mid = 1;
    temp = 8'd130; step(); step();
    check("R7 hysteresis blocks start", inhibit, 1);
    temp = 8'(T_LO - 1); step();
    check("R7 release delay", inhibit, 1);
    step();
    check("R7 restart after release", inhibit, 0);
    check("R1 bias off when running again", bias, 0);
    check("R8 cause kept across restart", cause, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule